// File: doc/BRIEF.md
# Fractional-Baud UART Transmitter and Receiver

This block is an asynchronous serial transmitter and receiver pair. Both sides share one integer divider that sets the bit period in clock cycles. An 11-bit mask on each side can lengthen individual bit positions of a frame by one clock. Spreading a few stretched bits across the frame gives an average baud rate that lies between two integer divisions. This lets a fixed system clock reach rates that the divider alone cannot express.

The transmitter accepts a byte through a valid/ready handshake and shifts it out least significant bit first. It sends one or two stop bits. Its divider is either the shared value or that value plus one.

The receiver waits for a low level on its synchronized input, checks the start bit half a period later, and then samples each further bit one stretched period after the previous sample. It returns every byte with a framing-error flag.

Frame bit positions are numbered as follows:
- 0: the start bit.
- 1 to 8: the data bits.
- 9: the first stop bit.
- 10: the second stop bit, used only in two-stop mode.

Bit n of either mask belongs to frame position n.

Top module: `uart_fracbaud`

## Requirements
- R1: While reset is held and after it is released, `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A transmitted frame is a low start bit, then the eight data bits least significant first, then high stop bits: one when `cfg_two_stop`=0, two when it is 1.
- R3: The transmit bit period is `cfg_div`+1 clocks when `cfg_tx_plus1`=0 and `cfg_div`+2 clocks when it is 1. A divider of 0 gives one clock per bit.
- R4: When bit n of `cfg_tx_corr` is 1, transmitted frame position n lasts exactly one clock longer. Other positions are unchanged.
- R5: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the last stop bit has run its full length, and it is high again in the cycle that follows.
- R6: The receiver checks the start bit (P0−1)/2 clocks (rounded down) after it first sees the synchronized line low, where P0 is the corrected period of position 0. If the line is high at that check, it drops the frame without output and waits for a new start.
- R7: After the start check, the receiver samples each later position one corrected period of that position after the previous sample. Bit n of `cfg_rx_corr` adds one clock to position n. At the last stop sample it pulses `rx_valid` for one cycle with the byte on `rx_data`, least significant bit first.
- R8: `rx_frame_err` is 1 with `rx_valid` when any sampled stop bit was low. In one-stop mode position 10 is not sampled, so a start bit that follows at once is received as a new frame.
- R9: The receiver always uses `cfg_div` without the transmit plus-one, so a receive mask of all ones matches a transmitter that has the plus-one selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 11 | Bit-period divider; the period is the value plus one |
| cfg_tx_plus1 | input | 1 | Transmitter uses the divider plus one |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_tx_corr | input | 11 | Per-position stretch mask for the transmitter |
| cfg_rx_corr | input | 11 | Per-position stretch mask for the receiver |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter is idle and can take a byte |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is complete |
| rx_frame_err | output | 1 | A stop bit of this byte was sampled low |

## Verification
The bench loops the serial output back into the receiver and checks every cycle of each transmitted frame against expected levels and stretched lengths. A mask applied to the wrong position, or an off-by-one reload, would show up as a level change one cycle early or late. Matched masks at small dividers, and a plus-one transmitter against a receiver whose mask is all ones, would drift out of the sampling window if the receiver's stretch or its choice of divider were wrong. Directed receive frames cover these cases:
- A low first or second stop bit, where a missed framing error would go unflagged.
- A one-stop frame followed at once by another start bit, where a design that sampled position 10 would flag an error or lose the second byte.
- A start glitch shorter than half a bit, which a design without the start check would turn into a spurious byte.

// File: rtl/uart_fracbaud.sv
module uart_fracbaud #(
  parameter int DIV_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 cfg_tx_plus1,
  input  logic                 cfg_two_stop,
  input  logic [DATA_W+2:0]    cfg_tx_corr,
  input  logic [DATA_W+2:0]    cfg_rx_corr,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 txd,
  input  logic                 rxd,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  localparam int FRAME = DATA_W + 3;
  localparam int IDX_W = $clog2(FRAME);
  localparam int CNT_W = DIV_W + 2;

  wire [IDX_W-1:0] last_idx = cfg_two_stop ? IDX_W'(FRAME-1) : IDX_W'(FRAME-2);

  // transmitter
  logic              tx_busy;
  logic [IDX_W-1:0]  tx_idx;
  logic [CNT_W-1:0]  tx_cnt;
  logic [DATA_W-1:0] tx_buf;

  wire [CNT_W-1:0] tx_base  = CNT_W'(cfg_div) + CNT_W'(cfg_tx_plus1);
  wire [IDX_W-1:0] tx_nidx  = tx_idx + 1'b1;
  wire [CNT_W-1:0] tx_first = tx_base + CNT_W'(cfg_tx_corr[0]);
  wire [CNT_W-1:0] tx_next  = tx_base + CNT_W'(cfg_tx_corr[tx_nidx]);
  wire             tx_in_data = tx_idx != '0 && tx_idx <= IDX_W'(DATA_W);

  assign tx_ready = !tx_busy;
  assign txd = !tx_busy || (tx_idx != '0 && (tx_idx > IDX_W'(DATA_W) || tx_buf[0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_idx  <= '0;
      tx_cnt  <= '0;
      tx_buf  <= '0;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        tx_busy <= 1'b1;
        tx_idx  <= '0;
        tx_cnt  <= tx_first;
        tx_buf  <= tx_data;
      end
    end else if (tx_cnt != '0) begin
      tx_cnt <= tx_cnt - 1'b1;
    end else if (tx_idx == last_idx) begin
      tx_busy <= 1'b0;
    end else begin
      tx_idx <= tx_nidx;
      tx_cnt <= tx_next;
      if (tx_in_data) tx_buf <= tx_buf >> 1;
    end
  end

  // receiver
  logic              rx_meta, rx_s;
  logic              rx_busy;
  logic [IDX_W-1:0]  rx_idx;
  logic [CNT_W-1:0]  rx_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic              rx_err;

  wire [CNT_W-1:0] rx_base = CNT_W'(cfg_div);
  wire [IDX_W-1:0] rx_nidx = rx_idx + 1'b1;
  wire [CNT_W-1:0] rx_half = (rx_base + CNT_W'(cfg_rx_corr[0])) >> 1;
  wire [CNT_W-1:0] rx_next = rx_base + CNT_W'(cfg_rx_corr[rx_nidx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_meta      <= 1'b1;
      rx_s         <= 1'b1;
      rx_busy      <= 1'b0;
      rx_idx       <= '0;
      rx_cnt       <= '0;
      rx_sh        <= '0;
      rx_err       <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_meta  <= rxd;
      rx_s     <= rx_meta;
      rx_valid <= 1'b0;
      if (!rx_busy) begin
        if (!rx_s) begin
          rx_busy <= 1'b1;
          rx_idx  <= '0;
          rx_cnt  <= rx_half;
          rx_err  <= 1'b0;
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - 1'b1;
      end else if (rx_idx == '0) begin
        if (rx_s) rx_busy <= 1'b0;
        else begin
          rx_idx <= rx_nidx;
          rx_cnt <= rx_next;
        end
      end else begin
        if (rx_idx <= IDX_W'(DATA_W)) rx_sh <= {rx_s, rx_sh[DATA_W-1:1]};
        else if (!rx_s) rx_err <= 1'b1;
        if (rx_idx == last_idx) begin
          rx_busy      <= 1'b0;
          rx_valid     <= 1'b1;
          rx_data      <= rx_sh;
          rx_frame_err <= rx_err || !rx_s;
        end else begin
          rx_idx <= rx_nidx;
          rx_cnt <= rx_next;
        end
      end
    end
  end

  a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !txd));
  a_r4_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_cnt != '0) |=> $stable(txd));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r6_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_idx == '0 && rx_cnt == '0 && rx_s) |=> (!rx_busy && !rx_valid));
  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> txd);
endmodule

// File: tb/test_uart_fracbaud.sv
`timescale 1ns/1ps
module test_uart_fracbaud;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] cfg_div = '0, cfg_tx_corr = '0, cfg_rx_corr = '0;
  logic cfg_tx_plus1 = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, loop = 1'b0, rxd_drv = 1'b1;
  logic tx_ready, txd, rx_valid, rx_frame_err, rxd;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0, rx_n = 0;
  logic [7:0] log_d [0:63];
  logic       log_e [0:63];

  always #2.5 clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  uart_fracbaud i_uart_fracbaud (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_tx_plus1(cfg_tx_plus1),
    .cfg_two_stop(cfg_two_stop), .cfg_tx_corr(cfg_tx_corr), .cfg_rx_corr(cfg_rx_corr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err));

  always @(negedge clk) if (rx_valid) begin
    log_d[rx_n[5:0]] = rx_data;
    log_e[rx_n[5:0]] = rx_frame_err;
    rx_n = rx_n + 1;
  end

  typedef struct packed {
    logic [10:0] div; logic plus1; logic two;
    logic [10:0] txc; logic [10:0] rxc; logic [7:0] data; logic lp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{11'd7,  1'b0, 1'b0, 11'h000, 11'h000, 8'hA5, 1'b1},
    '{11'd7,  1'b0, 1'b1, 11'h000, 11'h000, 8'h3C, 1'b1},
    '{11'd0,  1'b0, 1'b0, 11'h000, 11'h000, 8'h96, 1'b0},
    '{11'd3,  1'b0, 1'b0, 11'h555, 11'h555, 8'hC3, 1'b1},
    '{11'd20, 1'b1, 1'b1, 11'h000, 11'h7FF, 8'h5A, 1'b1},
    '{11'd5,  1'b0, 1'b1, 11'h401, 11'h401, 8'hFF, 1'b1},
    '{11'd1,  1'b1, 1'b0, 11'h0F0, 11'h000, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int nb, bad, first_bad, base;
    bit e;
    cfg_div = v.div; cfg_tx_plus1 = v.plus1; cfg_two_stop = v.two;
    cfg_tx_corr = v.txc; cfg_rx_corr = v.rxc; loop = v.lp;
    repeat (3) @(negedge clk);
    base = rx_n;
    nb = v.two ? 11 : 10;
    tx_data = v.data; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R5", "ready after accept", int'(tx_ready), 0);
    bad = 0; first_bad = -1;
    for (int i = 0; i < nb; i++) begin
      e = (i == 0) ? 1'b0 : (i <= 8) ? v.data[i-1] : 1'b1;
      for (int j = 0; j < int'(v.div) + int'(v.plus1) + 1 + int'(v.txc[i]); j++) begin
        if (i != 0 || j != 0) @(negedge clk);
        if (txd !== e || tx_ready !== 1'b0) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
      end
    end
    chk(bad == 0, "R2 R3 R4", "frame levels and lengths, first bad position", first_bad, -1);
    @(negedge clk);
    chk(tx_ready == 1'b1 && txd == 1'b1, "R5", "ready after last stop", int'(tx_ready), 1);
    if (v.lp) begin
      repeat (10) @(negedge clk);
      chk(rx_n == base + 1, "R9", "loopback byte count", rx_n - base, 1);
      chk(log_d[base[5:0]] == v.data, "R7", "loopback data", int'(log_d[base[5:0]]), int'(v.data));
      chk(log_e[base[5:0]] == 1'b0, "R8", "loopback framing flag", int'(log_e[base[5:0]]), 0);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd_drv = b;
    repeat (8) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic s1, input logic s2, input int nst);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(s1);
    if (nst == 2) drive_bit(s2);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);

    foreach (VECS[k]) run_vec(VECS[k]);

    loop = 1'b0; rxd_drv = 1'b1;
    cfg_div = 11'd7; cfg_tx_plus1 = 1'b0; cfg_tx_corr = '0; cfg_rx_corr = '0;

    // R8: first stop low
    cfg_two_stop = 1'b0;
    repeat (5) @(negedge clk);
    base = rx_n;
    rx_frame(8'h81, 1'b0, 1'b1, 1);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(rx_n == base + 1, "R8", "count with bad stop", rx_n - base, 1);
    chk(log_e[base[5:0]] == 1'b1, "R8", "flag with first stop low", int'(log_e[base[5:0]]), 1);
    chk(log_d[base[5:0]] == 8'h81, "R7", "data with bad stop", int'(log_d[base[5:0]]), 'h81);

    // R8: second stop low in two-stop mode
    cfg_two_stop = 1'b1;
    repeat (5) @(negedge clk);
    base = rx_n;
    rx_frame(8'h42, 1'b1, 1'b0, 2);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(rx_n == base + 1 && log_e[base[5:0]] == 1'b1, "R8", "flag with second stop low",
        int'(log_e[base[5:0]]), 1);

    // R8: one-stop mode, next start follows at once
    cfg_two_stop = 1'b0;
    repeat (5) @(negedge clk);
    base = rx_n;
    rx_frame(8'h11, 1'b1, 1'b1, 1);
    rx_frame(8'h22, 1'b1, 1'b1, 1);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(rx_n == base + 2, "R8", "back-to-back byte count", rx_n - base, 2);
    chk(log_d[base[5:0]] == 8'h11 && log_e[base[5:0]] == 1'b0, "R8", "first back-to-back byte",
        int'(log_d[base[5:0]]), 'h11);
    chk(log_d[6'(base + 1)] == 8'h22 && log_e[6'(base + 1)] == 1'b0, "R8", "second back-to-back byte",
        int'(log_d[6'(base + 1)]), 'h22);

    // R6: short low glitch
    base = rx_n;
    rxd_drv = 1'b0; repeat (2) @(negedge clk);
    rxd_drv = 1'b1; repeat (40) @(negedge clk);
    chk(rx_n == base, "R6", "glitch produced bytes", rx_n - base, 0);
    rx_frame(8'h7E, 1'b1, 1'b1, 1);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(rx_n == base + 1 && log_d[base[5:0]] == 8'h7E, "R6", "frame after glitch",
        int'(log_d[base[5:0]]), 'h7E);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule